// File: doc/BRIEF.md
# Prioritized Interrupt Controller Core

This block collects a small set of external interrupt inputs and presents them to one or more processors as one interrupt line per processor. Each source is set up by software through a vector/priority word and a destination word. The vector/priority word holds a mask, a priority, a vector, a polarity and a sense (edge or level). A read-only activity flag in the same word tells software when a masked source may be reprogrammed safely. The destination word is a bitmask of the processors that may take the source.

Each processor has a task-priority threshold, an acknowledge register and an end-of-interrupt register. A handler reads the acknowledge register to claim the winning source and get its vector. If nothing qualifies at that moment, the read returns a global spurious vector instead. A write of zero to the end-of-interrupt register retires the source being serviced. In-service sources nest by priority, so a strictly higher priority source can interrupt a handler that is already running. A read-only feature word reports how the core was built. All access goes through a simple synchronous register bus with one operation per cycle. Read data appears on the cycle after the read strobe.

Top module: `pic_core`

## Requirements
- R1: After reset every source word reads mask=1 with priority, vector, polarity and sense 0, every destination reads 0, every task priority reads the maximum (15), the spurious vector reads 0xFF and no interrupt output is asserted.
- R2: The source word at address 0x40+2*s has this layout: vector in bits [7:0], priority in [11:8], polarity in bit 16, sense in bit 17, activity in bit 30 and mask in bit 31. Writes to the activity bit have no effect. The destination word at 0x41+2*s holds the processor mask in its low bits.
- R3: The read-only feature word at address 0x00 returns version 2 in bits [7:0], source count minus one in [15:8] and processor count minus one in [23:16]. The spurious vector is at address 0x01.
- R4: A source whose mask bit is 1 is never delivered. Clearing the mask while the source is pending raises delivery on the next cycle.
- R5: Destination bit n routes a source to processor n. A source that is in service on any processor is not offered to any other processor.
- R6: A processor's output is asserted only when its best candidate has a priority strictly greater than both its task priority (register 0x80+4*c) and the highest priority it has in service. A source of priority 0 is therefore never delivered.
- R7: Among qualifying sources, the highest priority wins, and on equal priority the lowest source index wins.
- R8: A read of the acknowledge register at 0x81+4*c returns the winning vector and puts that source in service on processor c. With no qualifying source, the read returns the spurious vector and changes nothing.
- R9: Writing 0 to the end-of-interrupt register at 0x82+4*c retires processor c's highest-priority in-service source. A nonzero write there has no effect.
- R10: With sense=0, a source latches a rising edge of its input when polarity=1, or a falling edge when polarity=0. The latch is set even while the source is masked and is cleared when the source is acknowledged.
- R11: With sense=1, a source is pending whenever its input equals its polarity bit. It pends again after end-of-interrupt if the input is still active.
- R12: The activity bit reads 1 whenever the source is pending or in service on any processor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | NUM_SRC | Interrupt inputs, synchronous to clk |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe (acknowledge reads have side effects) |
| bus_addr_i | input | 8 | Word address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid the cycle after the read strobe |
| irq_o | output | NUM_CPU | Interrupt request, one per processor |

## Verification
The assertions assume that the source inputs are already synchronous to the clock and that the bus never asserts read and write in the same cycle. The checks on acknowledge and end-of-interrupt also assume that nothing else touches a processor's service state in the cycle being checked. The stimulus keeps to these limits: it changes inputs only on the falling clock edge and issues at most one bus operation per cycle. In the random phase it also keeps that single-operation discipline while it reshapes masks, priorities, senses, polarities and routes under live traffic.

// File: rtl/pic_pkg.sv
package pic_pkg;
    parameter int PRI_W  = 4;
    parameter int VEC_W  = 8;
    parameter int DATA_W = 32;
    parameter int ADDR_W = 8;
    parameter int PIC_VERSION = 2;

    localparam int PRI_LSB   = 8;
    localparam int POL_BIT   = 16;
    localparam int SENSE_BIT = 17;
    localparam int ACT_BIT   = 30;
    localparam int MASK_BIT  = 31;

    localparam logic [1:0] RGN_GLOBAL = 2'd0;
    localparam logic [1:0] RGN_SRC    = 2'd1;
    localparam logic [1:0] RGN_CPU    = 2'd2;

    localparam logic [1:0] CPU_TPRI = 2'd0;
    localparam logic [1:0] CPU_ACK  = 2'd1;
    localparam logic [1:0] CPU_EOI  = 2'd2;

    typedef struct packed {
        logic             mask;
        logic             sense;
        logic             pol;
        logic [PRI_W-1:0] pri;
        logic [VEC_W-1:0] vec;
    } src_cfg_t;
endpackage

// File: rtl/pic_src_cell.sv
module pic_src_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    input  logic pol_i,
    input  logic sense_i,
    input  logic ack_clr_i,
    output logic pending_o
);
    typedef struct packed {
        logic raw;
        logic prev;
        logic latch;
    } cell_t;

    cell_t cell_d, cell_q;
    logic  edge_hit;

    always_comb begin
        edge_hit     = pol_i ? (cell_q.raw & ~cell_q.prev) : (~cell_q.raw & cell_q.prev);
        cell_d.raw   = raw_i;
        cell_d.prev  = cell_q.raw;
        cell_d.latch = sense_i ? 1'b0 : ((cell_q.latch & ~ack_clr_i) | edge_hit);
        pending_o    = sense_i ? (cell_q.raw == pol_i) : cell_q.latch;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cell_q <= '0;
        else        cell_q <= cell_d;
    end

    // R10: an edge latch holds until acknowledged
    a_r10_edge_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (!sense_i && !ack_clr_i && cell_q.latch) |=> cell_q.latch);
endmodule

// File: rtl/pic_arbiter.sv
module pic_arbiter #(
    parameter int NUM_SRC = 4,
    parameter int PRI_W   = 4,
    localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic [NUM_SRC-1:0]            cand_i,
    input  logic [NUM_SRC-1:0][PRI_W-1:0] pri_i,
    output logic                          found_o,
    output logic [IDX_W-1:0]              idx_o,
    output logic [PRI_W-1:0]              pri_o
);
    // scan downwards with >= so the lowest index wins a tie
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        pri_o   = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (cand_i[i] && (!found_o || pri_i[i] >= pri_o)) begin
                found_o = 1'b1;
                idx_o   = IDX_W'(i);
                pri_o   = pri_i[i];
            end
        end
    end
endmodule

// File: rtl/pic_core.sv
module pic_core
    import pic_pkg::*;
#(
    parameter int NUM_SRC = 4,
    parameter int NUM_CPU = 2,
    parameter logic [VEC_W-1:0] SPUR_RESET = 8'hFF
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_SRC-1:0]  src_i,
    input  logic                bus_wr_i,
    input  logic                bus_rd_i,
    input  logic [ADDR_W-1:0]   bus_addr_i,
    input  logic [DATA_W-1:0]   bus_wdata_i,
    output logic [DATA_W-1:0]   bus_rdata_o,
    output logic [NUM_CPU-1:0]  irq_o
);
    localparam int SRC_IW = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
    localparam int CPU_IW = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1;
    localparam logic [4:0] NUM_SRC_L = 5'(NUM_SRC);
    localparam logic [3:0] NUM_CPU_L = 4'(NUM_CPU);

    typedef struct packed {
        src_cfg_t [NUM_SRC-1:0]              cfg;
        logic [NUM_SRC-1:0][NUM_CPU-1:0]     dest;
        logic [NUM_CPU-1:0][PRI_W-1:0]       tpri;
        logic [NUM_CPU-1:0][NUM_SRC-1:0]     isr;
        logic [VEC_W-1:0]                    spur;
        logic [DATA_W-1:0]                   rdata;
    } state_t;

    state_t st_d, st_q;

    // address decode
    logic [1:0]        rgn;
    logic [4:0]        s_full;
    logic [3:0]        c_full;
    logic              s_ok, c_ok, s_sel;
    logic [SRC_IW-1:0] s_idx;
    logic [CPU_IW-1:0] c_idx;
    logic [1:0]        c_fn;

    assign rgn    = bus_addr_i[7:6];
    assign s_full = bus_addr_i[5:1];
    assign s_sel  = bus_addr_i[0];
    assign c_full = bus_addr_i[5:2];
    assign c_fn   = bus_addr_i[1:0];
    assign s_ok   = s_full < NUM_SRC_L;
    assign c_ok   = c_full < NUM_CPU_L;
    assign s_idx  = s_full[SRC_IW-1:0];
    assign c_idx  = c_full[CPU_IW-1:0];

    logic [NUM_SRC-1:0]              pending, busy, ack_clr;
    logic [NUM_SRC-1:0][PRI_W-1:0]   src_pri;
    logic [NUM_CPU-1:0][NUM_SRC-1:0] cand;
    logic [NUM_CPU-1:0]              best_found, srv_found, grant;
    logic [NUM_CPU-1:0][SRC_IW-1:0]  best_idx, srv_idx;
    logic [NUM_CPU-1:0][PRI_W-1:0]   best_pri, srv_pri;
    logic [NUM_CPU-1:0]              ack_rd, ack_fire, eoi_fire;

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        pic_src_cell u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .raw_i    (src_i[s]),
            .pol_i    (st_q.cfg[s].pol),
            .sense_i  (st_q.cfg[s].sense),
            .ack_clr_i(ack_clr[s]),
            .pending_o(pending[s])
        );
        assign src_pri[s] = st_q.cfg[s].pri;
        always_comb begin
            busy[s] = 1'b0;
            for (int c = 0; c < NUM_CPU; c++) busy[s] = busy[s] | st_q.isr[c][s];
        end
    end

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
        for (genvar s = 0; s < NUM_SRC; s++) begin : g_cand
            assign cand[c][s] = pending[s] & ~st_q.cfg[s].mask & st_q.dest[s][c] & ~busy[s];
        end
        pic_arbiter #(.NUM_SRC(NUM_SRC), .PRI_W(PRI_W)) u_pick (
            .cand_i (cand[c]), .pri_i(src_pri),
            .found_o(best_found[c]), .idx_o(best_idx[c]), .pri_o(best_pri[c])
        );
        pic_arbiter #(.NUM_SRC(NUM_SRC), .PRI_W(PRI_W)) u_srv (
            .cand_i (st_q.isr[c]), .pri_i(src_pri),
            .found_o(srv_found[c]), .idx_o(srv_idx[c]), .pri_o(srv_pri[c])
        );
        assign grant[c] = best_found[c] && (best_pri[c] > st_q.tpri[c])
                       && (!srv_found[c] || best_pri[c] > srv_pri[c]);
    end

    assign irq_o = grant;

    // acknowledge / end-of-interrupt strobes
    always_comb begin
        ack_clr = '0;
        for (int c = 0; c < NUM_CPU; c++) begin
            ack_rd[c]   = bus_rd_i && rgn == RGN_CPU && c_ok && c_idx == CPU_IW'(c) && c_fn == CPU_ACK;
            ack_fire[c] = ack_rd[c] && grant[c];
            eoi_fire[c] = bus_wr_i && rgn == RGN_CPU && c_ok && c_idx == CPU_IW'(c)
                       && c_fn == CPU_EOI && bus_wdata_i == '0 && srv_found[c];
            for (int s = 0; s < NUM_SRC; s++)
                if (ack_fire[c] && best_idx[c] == SRC_IW'(s)) ack_clr[s] = 1'b1;
        end
    end

    always_comb begin
        logic [DATA_W-1:0] rd_word;
        st_d    = st_q;
        rd_word = '0;
        unique case (rgn)
            RGN_GLOBAL: begin
                if (bus_addr_i[5:0] == 6'd0) begin
                    rd_word[7:0]   = 8'(PIC_VERSION);
                    rd_word[15:8]  = 8'(NUM_SRC - 1);
                    rd_word[23:16] = 8'(NUM_CPU - 1);
                end else if (bus_addr_i[5:0] == 6'd1) begin
                    rd_word[VEC_W-1:0] = st_q.spur;
                end
            end
            RGN_SRC: if (s_ok) begin
                if (s_sel) rd_word[NUM_CPU-1:0] = st_q.dest[s_idx];
                else begin
                    rd_word[VEC_W-1:0]         = st_q.cfg[s_idx].vec;
                    rd_word[PRI_LSB +: PRI_W]  = st_q.cfg[s_idx].pri;
                    rd_word[POL_BIT]           = st_q.cfg[s_idx].pol;
                    rd_word[SENSE_BIT]         = st_q.cfg[s_idx].sense;
                    rd_word[ACT_BIT]           = pending[s_idx] | busy[s_idx];
                    rd_word[MASK_BIT]          = st_q.cfg[s_idx].mask;
                end
            end
            RGN_CPU: if (c_ok) begin
                if (c_fn == CPU_TPRI) rd_word[PRI_W-1:0] = st_q.tpri[c_idx];
                else if (c_fn == CPU_ACK)
                    rd_word[VEC_W-1:0] = grant[c_idx] ? st_q.cfg[best_idx[c_idx]].vec : st_q.spur;
            end
            default: rd_word = '0;
        endcase
        if (bus_rd_i) st_d.rdata = rd_word;

        if (bus_wr_i) begin
            if (rgn == RGN_GLOBAL && bus_addr_i[5:0] == 6'd1)
                st_d.spur = bus_wdata_i[VEC_W-1:0];
            if (rgn == RGN_SRC && s_ok) begin
                if (s_sel) st_d.dest[s_idx] = bus_wdata_i[NUM_CPU-1:0];
                else begin
                    st_d.cfg[s_idx].vec   = bus_wdata_i[VEC_W-1:0];
                    st_d.cfg[s_idx].pri   = bus_wdata_i[PRI_LSB +: PRI_W];
                    st_d.cfg[s_idx].pol   = bus_wdata_i[POL_BIT];
                    st_d.cfg[s_idx].sense = bus_wdata_i[SENSE_BIT];
                    st_d.cfg[s_idx].mask  = bus_wdata_i[MASK_BIT];
                end
            end
            if (rgn == RGN_CPU && c_ok && c_fn == CPU_TPRI)
                st_d.tpri[c_idx] = bus_wdata_i[PRI_W-1:0];
        end

        for (int c = 0; c < NUM_CPU; c++) begin
            if (ack_fire[c]) st_d.isr[c][best_idx[c]] = 1'b1;
            if (eoi_fire[c]) st_d.isr[c][srv_idx[c]]  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.spur  <= SPUR_RESET;
            for (int s = 0; s < NUM_SRC; s++) st_q.cfg[s].mask <= 1'b1;
            for (int c = 0; c < NUM_CPU; c++) st_q.tpri[c]     <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_rdata_o = st_q.rdata;

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_chk
        // R8: acknowledge with no request returns the spurious vector
        a_r8_spurious_ack: assert property (@(posedge clk) disable iff (!rst_n)
            (ack_rd[c] && !irq_o[c]) |=> bus_rdata_o == DATA_W'(st_q.spur));
        // R8: a granted acknowledge adds exactly one in-service source
        a_r8_ack_enters_service: assert property (@(posedge clk) disable iff (!rst_n)
            (ack_rd[c] && irq_o[c]) |=> $countones(st_q.isr[c]) == $countones($past(st_q.isr[c])) + 1);
        // R9: end-of-interrupt retires exactly one in-service source
        a_r9_eoi_retires_one: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr_i && rgn == RGN_CPU && c_ok && c_idx == CPU_IW'(c) && c_fn == CPU_EOI
             && bus_wdata_i == '0 && st_q.isr[c] != '0)
            |=> $countones(st_q.isr[c]) == $countones($past(st_q.isr[c])) - 1);
        // R6: maximum task priority silences the processor
        a_r6_task_max_quiet: assert property (@(posedge clk) disable iff (!rst_n)
            (st_q.tpri[c] == '1) |-> !irq_o[c]);
    end
endmodule

// File: tb/pic_core_tb.sv
module pic_core_tb;
    localparam int N = 4;
    localparam int M = 2;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] src_in = '0;
    logic         wr = 1'b0, rd = 1'b0;
    logic [7:0]   addr = '0;
    logic [31:0]  wdata = '0;
    logic [31:0]  rdata;
    logic [M-1:0] irq;

    pic_core #(.NUM_SRC(N), .NUM_CPU(M)) u_dut (
        .clk(clk), .rst_n(rst_n), .src_i(src_in), .bus_wr_i(wr), .bus_rd_i(rd),
        .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
    );

    always #4 clk = ~clk;

    int checks = 0, errors = 0;
    string cur_tag = "R1";

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference ----------------
    bit m_mask[N], m_sense[N], m_pol[N], m_raw[N], m_prev[N], m_latch[N];
    int m_pri[N], m_vec[N], m_dest[N], m_tpri[M], m_spur;
    bit m_isr[M][N];
    logic [31:0] exp_rd;
    bit rd_due = 0;

    function automatic bit pend(int s);
        return m_sense[s] ? (m_raw[s] == m_pol[s]) : m_latch[s];
    endfunction
    function automatic bit busy(int s);
        for (int c = 0; c < M; c++) if (m_isr[c][s]) return 1;
        return 0;
    endfunction
    function automatic int pick(int c);
        int b = -1;
        for (int s = 0; s < N; s++)
            if (pend(s) && !m_mask[s] && ((m_dest[s] >> c) & 1) == 1 && !busy(s))
                if (b < 0 || m_pri[s] > m_pri[b]) b = s;
        return b;
    endfunction
    function automatic int srv(int c);
        int b = -1;
        for (int s = 0; s < N; s++)
            if (m_isr[c][s] && (b < 0 || m_pri[s] > m_pri[b])) b = s;
        return b;
    endfunction
    function automatic bit fire(int c);
        int b = pick(c);
        int v = srv(c);
        int sp = (v < 0) ? -1 : m_pri[v];
        if (b < 0) return 0;
        return (m_pri[b] > m_tpri[c]) && (m_pri[b] > sp);
    endfunction

    always @(posedge clk) begin
        int a, rg, s, ss, c, fn, ack_c, ack_s, eoi_c, eoi_s;
        bit nl[N];
        bit edg;
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin
                m_mask[i] = 1; m_sense[i] = 0; m_pol[i] = 0; m_raw[i] = 0; m_prev[i] = 0;
                m_latch[i] = 0; m_pri[i] = 0; m_vec[i] = 0; m_dest[i] = 0;
                for (int k = 0; k < M; k++) m_isr[k][i] = 0;
            end
            for (int k = 0; k < M; k++) m_tpri[k] = 15;
            m_spur = 'hFF;
        end else begin
            a = int'(addr); rg = a >> 6; s = (a >> 1) & 31; ss = a & 1; c = (a >> 2) & 15; fn = a & 3;
            ack_c = -1; ack_s = -1; eoi_c = -1; eoi_s = -1;
            if (rd) begin
                exp_rd = 0;
                if (rg == 0 && a == 0) exp_rd = ((M - 1) << 16) | ((N - 1) << 8) | 2;
                else if (rg == 0 && a == 1) exp_rd = m_spur;
                else if (rg == 1 && s < N) begin
                    if (ss == 1) exp_rd = m_dest[s];
                    else exp_rd = m_vec[s] | (m_pri[s] << 8) | (int'(m_pol[s]) << 16)
                                | (int'(m_sense[s]) << 17) | (int'(pend(s) | busy(s)) << 30)
                                | (int'(m_mask[s]) << 31);
                end else if (rg == 2 && c < M) begin
                    if (fn == 0) exp_rd = m_tpri[c];
                    else if (fn == 1) begin
                        if (fire(c)) begin ack_c = c; ack_s = pick(c); exp_rd = m_vec[ack_s]; end
                        else exp_rd = m_spur;
                    end
                end
                rd_due = 1;
            end
            if (wr && rg == 2 && c < M && fn == 2 && wdata == 0 && srv(c) >= 0) begin
                eoi_c = c; eoi_s = srv(c);
            end
            for (int i = 0; i < N; i++) begin
                edg = m_pol[i] ? (m_raw[i] && !m_prev[i]) : (!m_raw[i] && m_prev[i]);
                nl[i] = m_sense[i] ? 0 : ((m_latch[i] && !(ack_s == i)) || edg);
            end
            for (int i = 0; i < N; i++) begin
                m_latch[i] = nl[i]; m_prev[i] = m_raw[i]; m_raw[i] = src_in[i];
            end
            if (ack_c >= 0) m_isr[ack_c][ack_s] = 1;
            if (eoi_c >= 0) m_isr[eoi_c][eoi_s] = 0;
            if (wr) begin
                if (rg == 0 && a == 1) m_spur = wdata & 'hFF;
                if (rg == 1 && s < N) begin
                    if (ss == 1) m_dest[s] = wdata & ((1 << M) - 1);
                    else begin
                        m_mask[s] = wdata[31]; m_sense[s] = wdata[17]; m_pol[s] = wdata[16];
                        m_pri[s] = (wdata >> 8) & 15; m_vec[s] = wdata & 'hFF;
                    end
                end
                if (rg == 2 && c < M && fn == 0) m_tpri[c] = wdata & 15;
            end
        end
    end

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            for (int c = 0; c < M; c++) chk(irq[c] == fire(c), {cur_tag, " irq"}, irq[c], fire(c));
            if (rd_due) begin
                chk(rdata == exp_rd, {cur_tag, " rdata"}, rdata, exp_rd);
                rd_due = 0;
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    function automatic logic [7:0] vp(int s);  return 8'(8'h40 + 2 * s); endfunction
    function automatic logic [7:0] dst(int s); return 8'(8'h41 + 2 * s); endfunction
    function automatic logic [7:0] tp(int c);  return 8'(8'h80 + 4 * c); endfunction
    function automatic logic [7:0] ak(int c);  return 8'(8'h81 + 4 * c); endfunction
    function automatic logic [7:0] eo(int c);  return 8'(8'h82 + 4 * c); endfunction
    function automatic logic [31:0] cw(bit mk, bit sn, bit pl, int pr, int vc);
        return {mk, 13'd0, sn, pl, 4'd0, 4'(pr), 8'(vc)};
    endfunction

    task automatic bus(input bit w, input bit r, input logic [7:0] a, input logic [31:0] d);
        wr = w; rd = r; addr = a; wdata = d;
        @(negedge clk);
        wr = 0; rd = 0;
    endtask
    task automatic wreg(input logic [7:0] a, input logic [31:0] d); bus(1, 0, a, d); endtask
    task automatic rd_expect(input logic [7:0] a, input logic [31:0] e, input string tag);
        bus(0, 1, a, 0);
        chk(rdata == e, tag, rdata, e);
    endtask
    task automatic idle(input int n); repeat (n) @(negedge clk); endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        cur_tag = "R1";
        chk(irq == 0, "R1 no irq", irq, 0);
        rd_expect(vp(0), 32'h8000_0000, "R1 source word");
        rd_expect(dst(2), 0, "R1 destination");
        rd_expect(tp(0), 15, "R1 task priority");
        rd_expect(8'h01, 32'hFF, "R1 spurious");

        cur_tag = "R3";
        rd_expect(8'h00, 32'h0001_0302, "R3 feature");

        cur_tag = "R2";
        wreg(vp(0), cw(1, 1, 1, 5, 'h20) | 32'h4000_0000);
        rd_expect(vp(0), 32'h8003_0520, "R2 layout, activity not writable");

        cur_tag = "R4";
        wreg(dst(0), 1); wreg(tp(0), 0);
        src_in[0] = 1; idle(3);
        chk(irq[0] == 0, "R4 masked source blocked", irq[0], 0);
        rd_expect(vp(0), 32'hC003_0520, "R12 activity while pending");
        wreg(vp(0), cw(0, 1, 1, 5, 'h20));
        chk(irq[0] == 1, "R4 unmask delivers", irq[0], 1);

        cur_tag = "R8";
        rd_expect(ak(0), 'h20, "R8 ack vector");
        chk(irq[0] == 0, "R8 in service drops request", irq[0], 0);
        rd_expect(vp(0), 32'h4003_0520, "R12 activity while in service");

        cur_tag = "R9";
        wreg(eo(0), 5); idle(2);
        chk(irq[0] == 0, "R9 nonzero eoi ignored", irq[0], 0);
        wreg(eo(0), 0);
        chk(irq[0] == 1, "R11 level re-raises after eoi", irq[0], 1);

        cur_tag = "R11";
        rd_expect(ak(0), 'h20, "R11 ack again");
        src_in[0] = 0; wreg(eo(0), 0); idle(2);
        chk(irq[0] == 0, "R11 released level stays quiet", irq[0], 0);
        rd_expect(ak(0), 'hFF, "R8 spurious when idle");

        cur_tag = "R10";
        src_in[1] = 1; idle(3);
        wreg(dst(1), 2); wreg(tp(1), 0);
        wreg(vp(1), cw(1, 0, 0, 3, 'h31));
        src_in[1] = 0; idle(3);
        chk(irq[1] == 0, "R10 masked edge", irq[1], 0);
        wreg(vp(1), cw(0, 0, 0, 3, 'h31));
        chk(irq[1] == 1, "R10 edge latched while masked", irq[1], 1);
        src_in[1] = 1;
        rd_expect(ak(1), 'h31, "R10 ack edge source");
        wreg(eo(1), 0); idle(2);
        chk(irq[1] == 0, "R10 latch cleared by ack", irq[1], 0);

        cur_tag = "R7";
        wreg(dst(2), 1); wreg(dst(3), 1);
        wreg(vp(2), cw(0, 0, 1, 6, 'h42)); wreg(vp(3), cw(0, 0, 1, 6, 'h43));
        src_in[2] = 1; src_in[3] = 1; idle(3);
        rd_expect(ak(0), 'h42, "R7 lowest index wins tie");
        chk(irq[0] == 0, "R6 equal priority does not preempt", irq[0], 0);
        wreg(eo(0), 0);
        chk(irq[0] == 1, "R7 second source follows", irq[0], 1);
        rd_expect(ak(0), 'h43, "R7 second vector");
        wreg(eo(0), 0);

        cur_tag = "R6";
        wreg(tp(0), 7);
        src_in[2] = 0; idle(2); src_in[2] = 1; idle(3);
        chk(irq[0] == 0, "R6 below threshold", irq[0], 0);
        wreg(tp(0), 5);
        chk(irq[0] == 1, "R6 above threshold", irq[0], 1);
        rd_expect(ak(0), 'h42, "R6 ack");
        wreg(eo(0), 0); wreg(tp(0), 0);
        wreg(vp(2), cw(0, 0, 1, 0, 'h42));
        src_in[2] = 0; idle(2); src_in[2] = 1; idle(3);
        chk(irq[0] == 0, "R6 zero priority never delivered", irq[0], 0);

        cur_tag = "R5";
        wreg(dst(3), 3);
        src_in[3] = 0; idle(2); src_in[3] = 1; idle(3);
        chk(irq == 2'b11, "R5 routed to both", irq, 3);
        rd_expect(ak(1), 'h43, "R5 ack on processor 1");
        chk(irq[0] == 0, "R5 busy source withheld", irq[0], 0);
        wreg(eo(1), 0);

        cur_tag = "R6";
        wreg(dst(3), 1);
        src_in[0] = 1; idle(2);
        rd_expect(ak(0), 'h20, "R6 low priority taken");
        src_in[3] = 0; idle(2); src_in[3] = 1; idle(3);
        chk(irq[0] == 1, "R6 higher priority preempts", irq[0], 1);
        rd_expect(ak(0), 'h43, "R6 nested ack");
        wreg(eo(0), 0);
        rd_expect(ak(0), 'hFF, "R9 retired highest first");
        wreg(eo(0), 0);
        chk(irq[0] == 1, "R11 level source pends again", irq[0], 1);
        src_in[0] = 0; idle(2);

        cur_tag = "R12";
        for (int i = 0; i < 3000; i++) begin
            for (int b = 0; b < N; b++) if ($urandom % 8 == 0) src_in[b] = ~src_in[b];
            case ($urandom % 8)
                0: wreg(vp($urandom % N), cw(($urandom % 4) == 0, $urandom % 2, $urandom % 2,
                                              $urandom % 16, $urandom % 256));
                1: wreg(dst($urandom % N), $urandom % 4);
                2: wreg(tp($urandom % M), $urandom % 8);
                3, 4: bus(0, 1, ak($urandom % M), 0);
                5: wreg(eo($urandom % M), ($urandom % 8 == 0) ? 1 : 0);
                6: bus(0, 1, 8'(($urandom % 2) ? vp($urandom % N) : tp($urandom % M)), 0);
                default: idle(1);
            endcase
        end

        idle(4);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog (all R) actual=timeout expected=completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule